// File: doc/BRIEF.md
# Fine-grain configurable logic cell

This block is one programmable cell of a cellular logic fabric. It has eight routing inputs: the four nearest neighbours (north, south, east, west) and four length-4 lines in the same directions. Three selectors each pick one of the eight inputs to form the operands X1, X2 and X3. Y2 is X2 and Y3 is X3, each passed either as it is or inverted. A single 2:1 multiplexer steered by X1 forms the function value F. The 2:1 multiplexer, AND, OR and XOR are all built this way by choosing which routing inputs feed X1, X2 and X3.

The cell output is either F itself or the output of a master-slave flip-flop that samples F. The flip-flop has a synchronous clear. One configuration bit chooses between the two paths, so only one of them drives the output at a time. Four directional output multiplexers drive the neighbours. Each one carries either the cell output or a signal passed through from the opposite side. A fifth routing multiplexer forwards any one of the eight inputs, independent of the logic.

All selections come from one configuration word, written through an enable and data port. A write takes effect at the clock edge that captures it.

Top module: `lc_cell`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) clears the configuration word and the flip-flop to zero. With an all-zero word, X1, X2 and X3 all take the north input, F equals the north input, the cell output is combinational, every directional output carries the cell output, and the routing output forwards north.
- R2: Each operand selector code is 3 bits: 0=N, 1=S, 2=E, 3=W, 4=N4, 5=S4, 6=E4, 7=W4. Near inputs are nb_in[0..3] and length-4 inputs are nb4_in[0..3], both in the order N, S, E, W.
- R3: F = X1 ? (X2 XOR inv2) : (X3 XOR inv3).
- R4: AND of A and B is formed with X1=A, X2=B, X3=A. OR of A and B is formed with X1=A, X2=A, X3=B, with both inversions off.
- R5: XOR of A and B is formed with X1=A, X2=B with inv2 set, X3=B. A 2:1 multiplexer is formed with X1 as the select, X2 as the data passed on 1 and X3 as the data passed on 0.
- R6: With use_reg set, cell_out equals the F sampled at the most recent rising edge. Input changes between edges do not reach cell_out.
- R7: With clr high at a rising edge, the flip-flop loads 0 whatever F is.
- R8: Directional output d (0=N, 1=S, 2=E, 3=W) takes a 2-bit mode: 0 gives the cell output, 1 gives the near input of the opposite side, 2 gives the length-4 input of the opposite side, and 3 gives constant 0.
- R9: magic_out forwards the input chosen by a 3-bit code with the same encoding as R2.
- R10: The configuration word layout, LSB first, is: X1 select [2:0], X2 select [5:3], X3 select [8:6], inv2 [9], inv3 [10], use_reg [11], directional mode d at [13+2d:12+2d], routing select [22:20]. A write with cfg_we high takes effect right after the capturing edge, including while the cell is running. Before that edge the old behaviour holds.
- R11: With use_reg clear, cell_out follows changes of the routing inputs within the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_wdata | input | 23 | Configuration word to write |
| clr | input | 1 | Synchronous clear of the flip-flop |
| nb_in | input | 4 | Nearest-neighbour inputs N, S, E, W |
| nb4_in | input | 4 | Length-4 inputs N4, S4, E4, W4 |
| cell_out | output | 1 | Cell output, F or the flip-flop value |
| dir_out | output | 4 | Outputs to the neighbours N, S, E, W |
| magic_out | output | 1 | Routing pass-through output |

## Verification
Combinational results (F, the directional outputs and the routing output) are due in the same cycle as the input change. The bench checks them one time step after it drives the inputs, with no clock edge in between. A configuration write is due one edge after cfg_we is driven, and the registered path and clear are also due one edge after their stimulus. The bench drives every input on the falling edge and checks twice: once before the next rising edge, to confirm the old value still holds, and again on the following falling edge, when the new value must be present.

// File: rtl/lc_pkg.sv
package lc_pkg;
    localparam int NDIR   = 4;
    localparam int NSRC   = 2 * NDIR;
    localparam int SEL_W  = $clog2(NSRC);
    localparam int MODE_W = 2;
    localparam int NOPER  = 3;

    typedef enum logic [SEL_W-1:0] {
        SRC_N, SRC_S, SRC_E, SRC_W, SRC_N4, SRC_S4, SRC_E4, SRC_W4
    } src_e;

    typedef enum logic [MODE_W-1:0] {
        DIR_CELL, DIR_PASS_NEAR, DIR_PASS_FAR, DIR_OFF
    } dir_mode_e;

    typedef struct packed {
        src_e                          magic_sel;
        logic [NDIR-1:0][MODE_W-1:0]   dir_mode;
        logic                          use_reg;
        logic                          inv3;
        logic                          inv2;
        src_e                          x3_sel;
        src_e                          x2_sel;
        src_e                          x1_sel;
    } cell_cfg_t;

    localparam int CFG_W = $bits(cell_cfg_t);

    function automatic logic pick_src(src_e s, logic [NDIR-1:0] near, logic [NDIR-1:0] far);
        return s[SEL_W-1] ? far[s[SEL_W-2:0]] : near[s[SEL_W-2:0]];
    endfunction

    function automatic int unsigned opposite(int unsigned d);
        return d ^ 1;
    endfunction
endpackage

// File: rtl/lc_in_mux.sv
module lc_in_mux
    import lc_pkg::*;
#(
    parameter int N_OUT = NOPER
) (
    input  src_e            sel   [N_OUT],
    input  logic [NDIR-1:0] near,
    input  logic [NDIR-1:0] far,
    output logic [N_OUT-1:0] x
);
    for (genvar i = 0; i < N_OUT; i++) begin : g_sel
        always_comb x[i] = pick_src(sel[i], near, far);
    end
endmodule

// File: rtl/lc_func_core.sv
module lc_func_core (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic x1,
    input  logic x2,
    input  logic x3,
    input  logic inv2,
    input  logic inv3,
    input  logic use_reg,
    output logic f,
    output logic q,
    output logic cell_out
);
    logic y2, y3;

    always_comb begin
        y2 = x2 ^ inv2;
        y3 = x3 ^ inv3;
        f  = x1 ? y2 : y3;
        cell_out = use_reg ? q : f;
    end

    // master-slave storage modelled as one edge-triggered stage
    always_ff @(posedge clk) begin
        if (rst || clr) q <= 1'b0;
        else            q <= f;
    end

    assert_reg_samples_f_R6: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(clr)) |-> (q == $past(f)));

    assert_clear_zeroes_q_R7: assert property (@(posedge clk) disable iff (rst)
        $past(clr) |-> !q);
endmodule

// File: rtl/lc_route.sv
module lc_route
    import lc_pkg::*;
(
    input  logic                        cell_out,
    input  logic [NDIR-1:0]             near,
    input  logic [NDIR-1:0]             far,
    input  logic [NDIR-1:0][MODE_W-1:0] dir_mode,
    input  src_e                        magic_sel,
    output logic [NDIR-1:0]             dir_out,
    output logic                        magic_out
);
    for (genvar d = 0; d < NDIR; d++) begin : g_dir
        localparam int OPP = int'(opposite(d));
        always_comb begin
            case (dir_mode_e'(dir_mode[d]))
                DIR_CELL:      dir_out[d] = cell_out;
                DIR_PASS_NEAR: dir_out[d] = near[OPP];
                DIR_PASS_FAR:  dir_out[d] = far[OPP];
                default:       dir_out[d] = 1'b0;
            endcase
        end
    end

    always_comb magic_out = pick_src(magic_sel, near, far);
endmodule

// File: rtl/lc_cell.sv
module lc_cell
    import lc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_we,
    input  logic [CFG_W-1:0]     cfg_wdata,
    input  logic                 clr,
    input  logic [NDIR-1:0]      nb_in,
    input  logic [NDIR-1:0]      nb4_in,
    output logic                 cell_out,
    output logic [NDIR-1:0]      dir_out,
    output logic                 magic_out
);
    cell_cfg_t        cfg_q;
    logic [NOPER-1:0] x;
    src_e             opsel [NOPER];
    logic             f, q;

    always_ff @(posedge clk) begin
        if (rst)         cfg_q <= '0;
        else if (cfg_we) cfg_q <= cell_cfg_t'(cfg_wdata);
    end

    always_comb begin
        opsel[0] = cfg_q.x1_sel;
        opsel[1] = cfg_q.x2_sel;
        opsel[2] = cfg_q.x3_sel;
    end

    lc_in_mux #(.N_OUT(NOPER)) u_in (
        .sel  (opsel),
        .near (nb_in),
        .far  (nb4_in),
        .x    (x)
    );

    lc_func_core u_core (
        .clk      (clk),
        .rst      (rst),
        .clr      (clr),
        .x1       (x[0]),
        .x2       (x[1]),
        .x3       (x[2]),
        .inv2     (cfg_q.inv2),
        .inv3     (cfg_q.inv3),
        .use_reg  (cfg_q.use_reg),
        .f        (f),
        .q        (q),
        .cell_out (cell_out)
    );

    lc_route u_route (
        .cell_out  (cell_out),
        .near      (nb_in),
        .far       (nb4_in),
        .dir_mode  (cfg_q.dir_mode),
        .magic_sel (cfg_q.magic_sel),
        .dir_out   (dir_out),
        .magic_out (magic_out)
    );

    assert_cfg_write_lands_R10: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(cfg_we)) |-> (cfg_q == $past(cfg_wdata)));

    assert_cfg_holds_R10: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(cfg_we)) |-> $stable(cfg_q));

    assert_reg_path_cleared_R7: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(clr) && cfg_q.use_reg) |-> !cell_out);

    assert_north_carries_cell_R8: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.dir_mode[0] == DIR_CELL) |-> (dir_out[0] == cell_out));
endmodule

// File: tb/lc_cell_tb_top.sv
module lc_cell_tb_top;
    localparam int CLK_P = 10;
    localparam int NV = 16;

    // {x1, x2, x3, inv2, inv3, nb_in, nb4_in, expected}
    localparam logic [19:0] VEC [NV] = '{
        {3'd0, 3'd0, 3'd0, 1'b0, 1'b0, 4'b0001, 4'b0000, 1'b1},
        {3'd0, 3'd0, 3'd0, 1'b0, 1'b0, 4'b0000, 4'b0000, 1'b0},
        {3'd2, 3'd7, 3'd2, 1'b0, 1'b0, 4'b0100, 4'b1000, 1'b1},
        {3'd2, 3'd7, 3'd2, 1'b0, 1'b0, 4'b0100, 4'b0000, 1'b0},
        {3'd2, 3'd7, 3'd2, 1'b0, 1'b0, 4'b0000, 4'b1000, 1'b0},
        {3'd1, 3'd1, 3'd4, 1'b0, 1'b0, 4'b0000, 4'b0001, 1'b1},
        {3'd1, 3'd1, 3'd4, 1'b0, 1'b0, 4'b0010, 4'b0000, 1'b1},
        {3'd1, 3'd1, 3'd4, 1'b0, 1'b0, 4'b0000, 4'b0000, 1'b0},
        {3'd3, 3'd5, 3'd5, 1'b1, 1'b0, 4'b1000, 4'b0010, 1'b0},
        {3'd3, 3'd5, 3'd5, 1'b1, 1'b0, 4'b1000, 4'b0000, 1'b1},
        {3'd3, 3'd5, 3'd5, 1'b1, 1'b0, 4'b0000, 4'b0010, 1'b1},
        {3'd3, 3'd5, 3'd5, 1'b1, 1'b0, 4'b0000, 4'b0000, 1'b0},
        {3'd6, 3'd0, 3'd1, 1'b0, 1'b0, 4'b0001, 4'b0100, 1'b1},
        {3'd6, 3'd0, 3'd1, 1'b0, 1'b0, 4'b0010, 4'b0100, 1'b0},
        {3'd6, 3'd0, 3'd1, 1'b0, 1'b0, 4'b0010, 4'b0000, 1'b1},
        {3'd0, 3'd0, 3'd2, 1'b0, 1'b1, 4'b0000, 4'b0000, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [22:0] cfg_wdata = '0;
    logic        clr = 1'b0;
    logic [3:0]  nb_in = '0;
    logic [3:0]  nb4_in = '0;
    logic        cell_out;
    logic [3:0]  dir_out;
    logic        magic_out;
    int checks = 0;
    int errors = 0;

    always #(CLK_P/2) clk = ~clk;

    lc_cell dut_i (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .clr(clr),
        .nb_in(nb_in), .nb4_in(nb4_in), .cell_out(cell_out), .dir_out(dir_out),
        .magic_out(magic_out)
    );

    function automatic logic [22:0] mk_cfg(logic [2:0] x1, logic [2:0] x2, logic [2:0] x3,
                                           logic i2, logic i3, logic ur,
                                           logic [7:0] dm, logic [2:0] mg);
        return {mg, dm, ur, i3, i2, x3, x2, x1};
    endfunction

    task automatic chk(string req, logic [3:0] act, logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic write_cfg(logic [22:0] v);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    initial begin
        #(CLK_P * 100000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state
        nb_in = 4'b0001;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R1 cell_out", {3'b0, cell_out}, 4'b0001);
        chk("R1 dir_out", dir_out, 4'b1111);
        chk("R1 magic_out", {3'b0, magic_out}, 4'b0001);

        // R2 R3 R4 R5 R11: vector table, combinational path
        for (int i = 0; i < NV; i++) begin
            logic [19:0] v;
            v = VEC[i];
            write_cfg(mk_cfg(v[19:17], v[16:14], v[13:11], v[10], v[9], 1'b0, 8'h00, 3'd0));
            nb_in = v[8:5];
            nb4_in = v[4:1];
            #1;
            chk("R3 table cell_out", {3'b0, cell_out}, {3'b0, v[0]});
            chk("R11 table north out", {3'b0, dir_out[0]}, {3'b0, v[0]});
        end

        // R6: registered path
        nb_in = 4'b0000; nb4_in = 4'b0000;
        write_cfg(mk_cfg(3'd0, 3'd0, 3'd0, 1'b0, 1'b0, 1'b1, 8'h00, 3'd0));
        @(negedge clk);
        nb_in = 4'b0001;
        #1;
        chk("R6 before edge", {3'b0, cell_out}, 4'b0000);
        @(negedge clk); #1;
        chk("R6 after edge", {3'b0, cell_out}, 4'b0001);
        nb_in = 4'b0000;
        #1;
        chk("R6 hold", {3'b0, cell_out}, 4'b0001);
        @(negedge clk); #1;
        chk("R6 falls", {3'b0, cell_out}, 4'b0000);

        // R7: synchronous clear
        nb_in = 4'b0001;
        @(negedge clk);
        clr = 1'b1;
        #1;
        chk("R7 before edge", {3'b0, cell_out}, 4'b0001);
        @(negedge clk); #1;
        chk("R7 cleared", {3'b0, cell_out}, 4'b0000);
        clr = 1'b0;
        @(negedge clk); #1;
        chk("R7 released", {3'b0, cell_out}, 4'b0001);

        // R8: directional modes; N=pass near, S=pass far, E=off, W=cell
        write_cfg(mk_cfg(3'd0, 3'd0, 3'd0, 1'b0, 1'b0, 1'b0, 8'b00_11_10_01, 3'd0));
        nb_in = 4'b0010; nb4_in = 4'b0001;
        #1;
        chk("R8 modes A", dir_out, 4'b0011);
        nb_in = 4'b0001; nb4_in = 4'b0000;
        #1;
        chk("R8 modes B", dir_out, 4'b1000);
        write_cfg(mk_cfg(3'd0, 3'd0, 3'd0, 1'b0, 1'b0, 1'b0, 8'b01_01_01_01, 3'd0));
        nb_in = 4'b1000;
        #1;
        chk("R8 east passes west", dir_out, 4'b0100);

        // R9: routing multiplexer
        write_cfg(mk_cfg(3'd0, 3'd0, 3'd0, 1'b0, 1'b0, 1'b0, 8'h00, 3'd7));
        nb_in = 4'b0000; nb4_in = 4'b1000;
        #1;
        chk("R9 W4", {3'b0, magic_out}, 4'b0001);
        write_cfg(mk_cfg(3'd0, 3'd0, 3'd0, 1'b0, 1'b0, 1'b0, 8'h00, 3'd2));
        nb_in = 4'b1011; nb4_in = 4'b1111;
        #1;
        chk("R9 E low", {3'b0, magic_out}, 4'b0000);

        // R10: write while running
        write_cfg(mk_cfg(3'd0, 3'd0, 3'd0, 1'b0, 1'b0, 1'b0, 8'h00, 3'd0));
        nb_in = 4'b0000; nb4_in = 4'b0000;
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = mk_cfg(3'd0, 3'd0, 3'd0, 1'b0, 1'b1, 1'b0, 8'h00, 3'd0);
        #1;
        chk("R10 old before edge", {3'b0, cell_out}, 4'b0000);
        @(negedge clk);
        cfg_we = 1'b0;
        #1;
        chk("R10 new after edge", {3'b0, cell_out}, 4'b0001);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule